// File: doc/BRIEF.md
# Eight-Mode Cartridge Bank Translator

This block sits between a CPU bus, a picture-processor pattern bus and two external RAMs: a 256 KiB program RAM and a 32 KiB character RAM. It turns each CPU address in the upper half of the address space into a physical program RAM address, and each pattern-table address into a physical character RAM address. It also produces the write enables for both memories. It emulates eight classic discrete-logic banking schemes. Software picks one at run time, together with the nametable mirroring type and whether program RAM is write-protected.

A single mode register is loaded by CPU writes to a four-byte window at $42FC-$42FF. The address lines and the data of that write both carry fields. While program RAM is write-protected, CPU writes to $8000-$FFFF load a 7-bit bank latch instead of the RAM. Each scheme reads its own fields of that latch, has its own fixed banks, and decides whether character RAM may be written. The block also drives a nametable page select from the mirroring code and the pattern bus address.

All outputs are combinational functions of the registered state and the current bus inputs. A register write takes effect on the clock edge that ends the write cycle.

Top module: `cart_bank_xlate`

## Requirements
- R1: After reset the block is in mode 0, the mirroring code is 2 (vertical), program RAM is writable, and both the bank latch and the retained character bank are 0.
- R2: A CPU write to an address whose bits 15..2 equal those of $42FC loads the mode register. The mode is data bits 7..5, the mirroring code is {address bit 0, data bit 4} with address bit 0 as the upper bit, and the protect flag is address bit 1. A write anywhere else leaves all three unchanged.
- R3: While unprotected, a CPU write to $8000-$FFFF raises `prgWe` in that cycle, and the bank latch keeps its value.
- R4: While protected, a CPU write to $8000-$FFFF loads data bits 6..0 into the bank latch and leaves `prgWe` low.
- R5: Mode 0 maps $8000-$BFFF to 16 KiB bank latch[2:0] and $C000-$FFFF to bank 7.
- R6: Mode 1 maps $8000-$BFFF to 16 KiB bank latch[6:2] (the bank is reduced to 4 bits by the 18-bit mask) and $C000-$FFFF to bank 7. The character bank is latch[1:0].
- R7: Mode 2 maps $8000-$BFFF to bank latch[3:0] and $C000-$FFFF to bank 15. Mode 3 maps $8000-$BFFF to bank 15 and $C000-$FFFF to bank latch[3:0].
- R8: Mode 4 maps $8000-$FFFF to 32 KiB bank latch[5:4]. The character bank is latch[1:0].
- R9: Mode 5 fixes 32 KiB bank 7 and takes the character bank from latch[1:0]. Mode 6 fixes 32 KiB bank 3 and takes the character bank from {0, latch[0]}. Mode 7 fixes 32 KiB bank 3.
- R10: In modes 0, 2, 3 and 7 the character bank stays at the value it last had in a mode with a character-bank field, even when the latch is rewritten.
- R11: `chrWe` equals `ppuWrite` when the mode is 0 to 3 and pattern address bit 13 is 0. Otherwise it is low.
- R12: `ntSel` is 0 for code 0, 1 for code 1, pattern address bit 10 for code 2, and bit 11 for code 3.
- R13: `prgAddr` is {16 KiB bank[3:0], CPU address[13:0]}; a 32 KiB bank b gives 16 KiB bank {b, CPU address bit 14}. `chrAddr` is {character bank[1:0], pattern address[12:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | CPU write strobe, one cycle per write |
| ppuAddr | input | 14 | Pattern/nametable bus address |
| ppuWrite | input | 1 | Pattern bus write strobe |
| prgAddr | output | 18 | Physical program RAM address |
| prgWe | output | 1 | Program RAM write enable |
| chrAddr | output | 15 | Physical character RAM address |
| chrWe | output | 1 | Character RAM write enable |
| mirrorCode | output | 2 | Current mirroring code |
| ntSel | output | 1 | Nametable page select |

## Verification
The bench walks through all eight modes in one run without resets, so stale state can be seen. If the character bank came from the latch in a field-less mode, it would change after the latch write in mode 7. If it were cleared on a mode switch, the value 3 carried from mode 1 into modes 2 and 3 would be lost. It also writes the upper half while unprotected and then reads back bank 0: a latch that loaded regardless of the protect flag would show bank 5 there. Mode-register writes just outside the window ($42FB, $4300) must leave the mode and mirroring unchanged, which catches a loose address compare. Swapping address bit 0 and data bit 4 in the mirroring code shows up as a wrong code after the writes that set them to differ.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

  typedef enum logic [2:0] {
    MODE_UN16    = 3'd0,
    MODE_WIDE16  = 3'd1,
    MODE_UO16    = 3'd2,
    MODE_UO16REV = 3'd3,
    MODE_G32     = 3'd4,
    MODE_C32A    = 3'd5,
    MODE_C32B    = 3'd6,
    MODE_N32     = 3'd7
  } bankMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic modeWr;
    logic latchWr;
  } ctrlStrobe_t;

  localparam int unsigned FIX_LOW16  = 7;
  localparam int unsigned FIX_HIGH16 = 15;
  localparam int unsigned FIX32_A    = 7;
  localparam int unsigned FIX32_B    = 3;

endpackage

// File: rtl/cbx_ctrl.sv
module cbx_ctrl
  import cbx_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter logic [CPU_AW-1:0] MODE_BASE = 16'h42FC
) (
  input  logic [CPU_AW-1:2] cpuAddrHi,
  input  logic              cpuWrite,
  input  logic              protectQ,
  output ctrlStrobe_t       strb,
  output logic              prgWe
);

  logic modeHit;
  logic upperHalf;

  assign modeHit   = (cpuAddrHi == MODE_BASE[CPU_AW-1:2]);
  assign upperHalf = cpuAddrHi[CPU_AW-1];

  always_comb begin
    strb.modeWr  = cpuWrite && modeHit;
    strb.latchWr = cpuWrite && upperHalf && protectQ;
    prgWe        = cpuWrite && upperHalf && !protectQ;
  end

endmodule

// File: rtl/cbx_datapath.sv
module cbx_datapath
  import cbx_pkg::*;
#(
  parameter int unsigned PRG_AW = 18,
  parameter int unsigned CHR_AW = 15,
  parameter int unsigned PPU_AW = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [14:0]       cpuAddrLo,
  input  logic [DATA_W-1:0] cpuData,
  input  logic [PPU_AW-1:0] ppuAddr,
  input  logic              ppuWrite,
  output logic              protectQ,
  output logic [PRG_AW-1:0] prgAddr,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              chrWe,
  output logic [1:0]        mirrorCode,
  output logic              ntSel
);

  localparam int unsigned OFS16   = 14;
  localparam int unsigned CHR_OFS = 13;
  localparam int unsigned CHR_BW  = CHR_AW - CHR_OFS;
  localparam int unsigned LATCH_W = DATA_W - 1;
  localparam int unsigned BANK_W  = 5;
  localparam int unsigned FULL_W  = BANK_W + OFS16;

  bankMode_e            modeQ;
  logic [1:0]           mirrorQ;
  logic [LATCH_W-1:0]   latchQ;
  logic [CHR_BW-1:0]    chrHoldQ;

  logic [BANK_W-1:0]    bank16;
  logic [FULL_W-1:0]    prgFull;
  logic                 unusedPrgHi;
  logic                 hasChrField;
  logic [CHR_BW-1:0]    chrField;
  logic [CHR_BW-1:0]    chrBank;
  logic                 chrWritable;
  logic                 a14;

  // registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeQ    <= MODE_UN16;
      mirrorQ  <= 2'd2;
      protectQ <= 1'b0;
      latchQ   <= '0;
      chrHoldQ <= '0;
    end else begin
      if (strb.modeWr) begin
        modeQ    <= bankMode_e'(cpuData[DATA_W-1:DATA_W-3]);
        mirrorQ  <= {cpuAddrLo[0], cpuData[4]};
        protectQ <= cpuAddrLo[1];
      end
      if (strb.latchWr) begin
        latchQ <= cpuData[LATCH_W-1:0];
      end
      if (hasChrField) begin
        chrHoldQ <= chrField;
      end
    end
  end

  assign a14 = cpuAddrLo[OFS16];

  // program bank arithmetic
  always_comb begin
    unique case (modeQ)
      MODE_UN16:    bank16 = a14 ? BANK_W'(FIX_LOW16)  : BANK_W'(latchQ[2:0]);
      MODE_WIDE16:  bank16 = a14 ? BANK_W'(FIX_LOW16)  : BANK_W'(latchQ[6:2]);
      MODE_UO16:    bank16 = a14 ? BANK_W'(FIX_HIGH16) : BANK_W'(latchQ[3:0]);
      MODE_UO16REV: bank16 = a14 ? BANK_W'(latchQ[3:0]) : BANK_W'(FIX_HIGH16);
      MODE_G32:     bank16 = BANK_W'({latchQ[5:4], a14});
      MODE_C32A:    bank16 = BANK_W'({3'(FIX32_A), a14});
      default:      bank16 = BANK_W'({2'(FIX32_B), a14});
    endcase
  end

  assign prgFull     = {bank16, cpuAddrLo[OFS16-1:0]};
  assign prgAddr     = prgFull[PRG_AW-1:0];
  assign unusedPrgHi = ^prgFull[FULL_W-1:PRG_AW];

  // character bank selection
  always_comb begin
    hasChrField = 1'b0;
    chrField    = latchQ[CHR_BW-1:0];
    unique case (modeQ)
      MODE_WIDE16, MODE_G32, MODE_C32A: hasChrField = 1'b1;
      MODE_C32B: begin
        hasChrField = 1'b1;
        chrField    = {{(CHR_BW-1){1'b0}}, latchQ[0]};
      end
      default: hasChrField = 1'b0;
    endcase
  end

  assign chrBank     = hasChrField ? chrField : chrHoldQ;
  assign chrWritable = (modeQ == MODE_UN16) || (modeQ == MODE_WIDE16) ||
                       (modeQ == MODE_UO16) || (modeQ == MODE_UO16REV);
  assign chrAddr     = {chrBank, ppuAddr[CHR_OFS-1:0]};
  assign chrWe       = ppuWrite && !ppuAddr[CHR_OFS] && chrWritable;

  // nametable page select
  always_comb begin
    unique case (mirrorQ)
      2'd0:    ntSel = 1'b0;
      2'd1:    ntSel = 1'b1;
      2'd2:    ntSel = ppuAddr[10];
      default: ntSel = ppuAddr[11];
    endcase
  end

  assign mirrorCode = mirrorQ;

endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
  import cbx_pkg::*;
#(
  parameter int unsigned CPU_AW = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned PPU_AW = 14,
  parameter int unsigned PRG_AW = 18,
  parameter int unsigned CHR_AW = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  input  logic              cpuWrite,
  input  logic [PPU_AW-1:0] ppuAddr,
  input  logic              ppuWrite,
  output logic [PRG_AW-1:0] prgAddr,
  output logic              prgWe,
  output logic [CHR_AW-1:0] chrAddr,
  output logic              chrWe,
  output logic [1:0]        mirrorCode,
  output logic              ntSel
);

  ctrlStrobe_t strb;
  logic        protectQ;

  cbx_ctrl #(.CPU_AW(CPU_AW)) ctrl_i (
    .cpuAddrHi (cpuAddr[CPU_AW-1:2]),
    .cpuWrite  (cpuWrite),
    .protectQ  (protectQ),
    .strb      (strb),
    .prgWe     (prgWe)
  );

  cbx_datapath #(
    .PRG_AW (PRG_AW),
    .CHR_AW (CHR_AW),
    .PPU_AW (PPU_AW),
    .DATA_W (DATA_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cpuAddrLo  (cpuAddr[14:0]),
    .cpuData    (cpuData),
    .ppuAddr    (ppuAddr),
    .ppuWrite   (ppuWrite),
    .protectQ   (protectQ),
    .prgAddr    (prgAddr),
    .chrAddr    (chrAddr),
    .chrWe      (chrWe),
    .mirrorCode (mirrorCode),
    .ntSel      (ntSel)
  );

endmodule

// File: rtl/cbx_chk.sv
module cbx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpuAddr,
  input logic [7:0]  cpuData,
  input logic        cpuWrite,
  input logic [13:0] ppuAddr,
  input logic        ppuWrite,
  input logic        prgWe,
  input logic        chrWe,
  input logic [1:0]  mirrorCode
);

  logic modeWrite;
  assign modeWrite = cpuWrite && (cpuAddr[15:2] == 14'h10BF);

  // R1
  reset_mirror_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (mirrorCode == 2'd2));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    modeWrite |=> (mirrorCode == {$past(cpuAddr[0]), $past(cpuData[4])}));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !modeWrite |=> $stable(mirrorCode));

  // R3
  prg_we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prgWe |-> (cpuWrite && cpuAddr[15]));

  // R4
  protect_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeWrite && cpuAddr[1]) |=> !prgWe);

  // R11
  chr_we_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chrWe |-> (ppuWrite && !ppuAddr[13]));

endmodule

bind cart_bank_xlate cbx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpuAddr    (cpuAddr),
  .cpuData    (cpuData),
  .cpuWrite   (cpuWrite),
  .ppuAddr    (ppuAddr),
  .ppuWrite   (ppuWrite),
  .prgWe      (prgWe),
  .chrWe      (chrWe),
  .mirrorCode (mirrorCode)
);

// File: tb/cart_bank_xlate_tb.sv
module cart_bank_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWrite = 1'b0;
  logic [13:0] ppuAddr = '0;
  logic        ppuWrite = 1'b0;
  logic [17:0] prgAddr;
  logic        prgWe;
  logic [14:0] chrAddr;
  logic        chrWe;
  logic [1:0]  mirrorCode;
  logic        ntSel;

  always #5 clk = ~clk;

  cart_bank_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .cpuData(cpuData),
    .cpuWrite(cpuWrite), .ppuAddr(ppuAddr), .ppuWrite(ppuWrite),
    .prgAddr(prgAddr), .prgWe(prgWe), .chrAddr(chrAddr), .chrWe(chrWe),
    .mirrorCode(mirrorCode), .ntSel(ntSel)
  );

  typedef struct {
    logic [17:0] ePrg;
    logic [14:0] eChr;
    logic        ePwe;
    logic        eCwe;
    logic [1:0]  eMir;
    logic        eNt;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic ntExp(input logic [1:0] m, input logic [13:0] pa);
    case (m)
      2'd0: return 1'b0;
      2'd1: return 1'b1;
      2'd2: return pa[10];
      default: return pa[11];
    endcase
  endfunction

  task automatic probe(input logic [15:0] a, input logic [7:0] d, input logic w,
                       input logic [13:0] pa, input logic pw,
                       input logic [17:0] ePrg, input logic [14:0] eChr,
                       input logic ePwe, input logic eCwe, input logic [1:0] eMir,
                       input string tag);
    item_t it;
    @(posedge clk); #2;
    cpuAddr = a; cpuData = d; cpuWrite = w; ppuAddr = pa; ppuWrite = pw;
    it.ePrg = ePrg; it.eChr = eChr; it.ePwe = ePwe; it.eCwe = eCwe;
    it.eMir = eMir; it.eNt = ntExp(eMir, pa); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        cmp(it.tag, "prgAddr", 32'(prgAddr), 32'(it.ePrg));
        cmp(it.tag, "chrAddr", 32'(chrAddr), 32'(it.eChr));
        cmp(it.tag, "prgWe", 32'(prgWe), 32'(it.ePwe));
        cmp(it.tag, "chrWe", 32'(chrWe), 32'(it.eCwe));
        cmp(it.tag, "mirrorCode", 32'(mirrorCode), 32'(it.eMir));
        cmp(it.tag, "ntSel", 32'(ntSel), 32'(it.eNt));
      end
    end
  end

  // watchdog
  initial begin
    #(10 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // driver
  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state, R5 mode 0 lower window, R12 vertical
    probe(16'h8123, 8'h00, 0, 14'h0456, 0, 18'h00123, 15'h0456, 0, 0, 2, "R1");
    // R3 unprotected write raises prgWe, R11 mode 0 char writable
    probe(16'h8000, 8'h55, 1, 14'h0000, 1, 18'h00000, 15'h0000, 1, 1, 2, "R3");
    // R3 latch ignored: still bank 0
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h00000, 15'h0000, 0, 0, 2, "R3_latch");
    probe(16'hC000, 8'h00, 0, 14'h0000, 0, 18'h1C000, 15'h0000, 0, 0, 2, "R5");
    // R11 nametable area never writes char RAM, R12 vertical pages
    probe(16'h8000, 8'h00, 0, 14'h2400, 1, 18'h00000, 15'h0400, 0, 0, 2, "R11");
    probe(16'h8000, 8'h00, 0, 14'h2800, 0, 18'h00000, 15'h0800, 0, 0, 2, "R12");
    // R2 mode 0 protected, mirror code {A0=0,D4=1}=1
    probe(16'h42FE, 8'h10, 1, 14'h0000, 0, 18'h1C2FE, 15'h0000, 0, 0, 2, "R2");
    // R4 latch write with no prgWe
    probe(16'h8000, 8'h05, 1, 14'h0000, 0, 18'h00000, 15'h0000, 0, 0, 1, "R4");
    probe(16'h9234, 8'h00, 0, 14'h2800, 0, 18'h15234, 15'h0800, 0, 0, 1, "R5");
    probe(16'hC010, 8'h00, 0, 14'h0000, 0, 18'h1C010, 15'h0000, 0, 0, 1, "R5");
    // mode 1
    probe(16'h42FF, 8'h20, 1, 14'h0000, 0, 18'h1C2FF, 15'h0000, 0, 0, 1, "R2");
    probe(16'hFFFF, 8'h4B, 1, 14'h0000, 0, 18'h1FFFF, 15'h2000, 0, 0, 2, "R6");
    probe(16'h8001, 8'h00, 0, 14'h0001, 1, 18'h08001, 15'h6001, 0, 1, 2, "R6");
    // mode 2: char bank 3 carried (R10)
    probe(16'h42FE, 8'h40, 1, 14'h0000, 0, 18'h1C2FE, 15'h6000, 0, 0, 2, "R2");
    probe(16'h8000, 8'h00, 0, 14'h0010, 1, 18'h2C000, 15'h6010, 0, 1, 0, "R7");
    probe(16'hC000, 8'h00, 0, 14'h0000, 0, 18'h3C000, 15'h6000, 0, 0, 0, "R7");
    probe(16'h8000, 8'h00, 1, 14'h0000, 0, 18'h2C000, 15'h6000, 0, 0, 0, "R4");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h00000, 15'h6000, 0, 0, 0, "R10");
    // mode 3
    probe(16'h42FE, 8'h60, 1, 14'h0000, 0, 18'h3C2FE, 15'h6000, 0, 0, 0, "R2");
    probe(16'h8000, 8'h09, 1, 14'h0000, 0, 18'h3C000, 15'h6000, 0, 0, 0, "R4");
    probe(16'h8005, 8'h00, 0, 14'h0000, 0, 18'h3C005, 15'h6000, 0, 0, 0, "R7");
    probe(16'hC005, 8'h00, 0, 14'h0000, 1, 18'h24005, 15'h6000, 0, 1, 0, "R7_rev");
    // mode 4
    probe(16'h42FF, 8'h80, 1, 14'h0000, 0, 18'h242FF, 15'h6000, 0, 0, 0, "R2");
    probe(16'h8000, 8'h21, 1, 14'h0000, 0, 18'h00000, 15'h2000, 0, 0, 2, "R8");
    probe(16'hC123, 8'h00, 0, 14'h0100, 1, 18'h14123, 15'h2100, 0, 0, 2, "R8");
    // mode 5
    probe(16'h42FE, 8'hB0, 1, 14'h0000, 0, 18'h142FE, 15'h2000, 0, 0, 2, "R2");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h38000, 15'h2000, 0, 0, 1, "R9");
    probe(16'h8000, 8'h02, 1, 14'h0000, 0, 18'h38000, 15'h2000, 0, 0, 1, "R4");
    probe(16'hFFFF, 8'h00, 0, 14'h0000, 1, 18'h3FFFF, 15'h4000, 0, 0, 1, "R9");
    // mode 6
    probe(16'h42FF, 8'hC0, 1, 14'h0000, 0, 18'h3C2FF, 15'h4000, 0, 0, 1, "R2");
    probe(16'h8000, 8'h03, 1, 14'h0000, 0, 18'h18000, 15'h0000, 0, 0, 2, "R9");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h18000, 15'h2000, 0, 0, 2, "R9");
    // mode 7 unprotected
    probe(16'h42FC, 8'hF0, 1, 14'h0000, 0, 18'h1C2FC, 15'h2000, 0, 0, 2, "R2");
    probe(16'h8000, 8'h00, 1, 14'h0000, 1, 18'h18000, 15'h2000, 1, 0, 1, "R3");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h18000, 15'h2000, 0, 0, 1, "R13");
    // mode 7 protected: latch write must not move char bank
    probe(16'h42FE, 8'hE0, 1, 14'h0000, 0, 18'h1C2FE, 15'h2000, 0, 0, 1, "R2");
    probe(16'h8000, 8'hFC, 1, 14'h0000, 0, 18'h18000, 15'h2000, 0, 0, 0, "R4");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h18000, 15'h2000, 0, 0, 0, "R10");
    // back to mode 6 with horizontal mirroring: latch took 0xFC
    probe(16'h42FF, 8'hD0, 1, 14'h0000, 0, 18'h1C2FF, 15'h2000, 0, 0, 0, "R2");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h18000, 15'h0000, 0, 0, 3, "R10");
    probe(16'h8000, 8'h00, 0, 14'h2800, 0, 18'h18000, 15'h0800, 0, 0, 3, "R12");
    probe(16'h8000, 8'h00, 0, 14'h2400, 0, 18'h18000, 15'h0400, 0, 0, 3, "R12");
    // R2 writes just outside the window change nothing
    probe(16'h42FB, 8'h00, 1, 14'h0000, 0, 18'h1C2FB, 15'h0000, 0, 0, 3, "R2_out");
    probe(16'h4300, 8'h00, 1, 14'h0000, 0, 18'h1C300, 15'h0000, 0, 0, 3, "R2_out");
    probe(16'h8000, 8'h00, 0, 14'h0000, 0, 18'h18000, 15'h0000, 0, 0, 3, "R2_out");
    @(posedge clk); #2;
    cpuWrite = 1'b0; ppuWrite = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule